// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt signal to a host processor. Each line is captured on a rising edge or by level, filtered through a mask, and ranked either in a fixed order or in a rotating order. Three bit-per-line registers hold the state: a pending register for requests not yet acknowledged, an in-service register for requests acknowledged but not yet retired, and a mask register for lines that must not be signalled. The interrupt output rises only when the best eligible request outranks everything currently in service, so a higher-priority request can nest inside a lower one that is still being serviced.

The host answers the interrupt with a one-cycle acknowledge pulse. During that cycle the block presents an 8-bit vector. The vector is the programmed base with its low three bits replaced by the winning level. If no eligible request is left by the time the acknowledge arrives, the block returns the level-7 vector and marks nothing in service, which the host treats as spurious. Service is retired by end-of-interrupt commands written through a small register port. A non-specific command retires the highest-ranked in-service level; a specific command names its level. An automatic mode makes the retirement unnecessary. A poll strobe gives software the same decision as a status byte, in place of a vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the mask, base and in-service register are clear, capture is edge mode with fixed priority and no automatic end-of-interrupt, so an acknowledge returns vector 0x07.
- R2: In edge mode (mode bit 0 = 0) a rising edge on a line is captured at the next clock and raises the interrupt output from then on. The request is dropped as soon as the line falls. A line held high after its acknowledge does not request again until it falls and rises.
- R3: In level mode (mode bit 0 = 1) a line requests for exactly as long as it is high, with no clock delay between line and interrupt output.
- R4: A line whose bit is set in the mask register (address 1) never raises the interrupt output and is never chosen by an acknowledge.
- R5: Under fixed priority (mode bit 1 = 0) the lowest-numbered eligible line wins, and the vector is {base[7:3], level}.
- R6: An acknowledge that finds a winner sets that level's in-service bit and clears its edge capture. The interrupt output is high only while the best eligible level ranks strictly above every in-service level.
- R7: An acknowledge with no eligible winner returns {base[7:3], 3'd7} and changes no in-service bit.
- R8: Writing address 3 with bit 3 = 0 (non-specific end-of-interrupt) clears the highest-ranked in-service bit. It does nothing when none is set.
- R9: Writing address 3 with bit 3 = 1 clears the in-service bit of the level in bits 2:0, whatever its rank.
- R10: Under rotating priority (mode bit 1 = 1) the level retired by an end-of-interrupt becomes the lowest rank and the next level up becomes the highest. Returning to fixed priority restores level 0 as highest.
- R11: In automatic end-of-interrupt mode (mode bit 2 = 1) an acknowledge leaves the in-service register unchanged. Under rotating priority it also makes the acknowledged level the lowest rank.
- R12: The poll status is {1, 4'b0000, level} when an eligible winner exists and 0x00 otherwise. A poll strobe with a winner acknowledges that level exactly as an acknowledge would.
- R13: A write to address 2 sets the vector base. The low three bits of the written value are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Request lines, level 0 to 7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 mask, 2 vector base, 3 end-of-interrupt |
| wr_data | input | 8 | Write data |
| ack | input | 1 | One-cycle interrupt acknowledge |
| vec_out | output | 8 | Vector returned for the current decision |
| poll_rd | input | 1 | One-cycle poll strobe |
| poll_data | output | 8 | Poll status byte |
| int_out | output | 1 | Interrupt to the host |

## Verification
The assertions assume that acknowledge and poll strobes never arrive in the same cycle. They also assume that request lines stay steady across an acknowledge, and they do not judge in-service changes in cycles where an end-of-interrupt write coincides with an acknowledge. The bench keeps to these limits: it drives one strobe at a time, changes lines only between handshakes, and issues end-of-interrupt commands in cycles of their own. The level count is taken to be a power of two, so rank arithmetic wraps without correction.

// File: rtl/irq_prio_pkg.sv
// Shared definitions for the priority interrupt controller.
// Assumes a two-bit register address on the write port.
package irq_prio_pkg;
    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_MASK = 2'd1,
        REG_BASE = 2'd2,
        REG_EOI  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic auto_eoi;   // bit 2
        logic rotate;     // bit 1
        logic level;      // bit 0
    } mode_t;
endpackage

// File: rtl/irq_capture.sv
// Request capture: turns raw lines into pending bits.
// Edge mode latches a rising edge and drops it when the line falls or the
// level is acknowledged; level mode passes the lines straight through.
// Assumes lines are synchronous to clk.
module irq_capture #(
    parameter int NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_mode,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic [NUM_LVL-1:0] clr,
    output logic [NUM_LVL-1:0] pend
);
    logic [NUM_LVL-1:0] irq_prev;
    logic [NUM_LVL-1:0] edge_lat;

    // Track previous line state and hold captured edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_prev <= '0;
            edge_lat <= '0;
        end else begin
            irq_prev <= irq_in;
            edge_lat <= (edge_lat | (irq_in & ~irq_prev)) & irq_in & ~clr;
        end
    end

    // Select the pending view for the configured trigger mode.
    always_comb begin
        pend = level_mode ? irq_in : (edge_lat & irq_in);
    end
endmodule

// File: rtl/irq_resolver.sv
// Rank resolver: finds the highest-ranked set bit of a request vector.
// The lowest-ranked level is low_lvl; ranking starts one above it and wraps.
// Assumes NUM_LVL is a power of two so level arithmetic wraps naturally.
module irq_resolver #(
    parameter int NUM_LVL = 8,
    localparam int LW     = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] req,
    input  logic [LW-1:0]      low_lvl,
    output logic               hit,
    output logic [LW-1:0]      lvl,
    output logic [LW-1:0]      rank
);
    // Scan levels in rank order and keep the first one requested.
    always_comb begin
        logic [LW-1:0] idx;
        hit  = 1'b0;
        lvl  = '0;
        rank = '0;
        for (int k = 0; k < NUM_LVL; k++) begin
            idx = low_lvl + LW'(k + 1);
            if (!hit && req[idx]) begin
                hit  = 1'b1;
                lvl  = idx;
                rank = LW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Priority interrupt controller top.
// Holds mode, mask, vector base, in-service and rotation state; decides the
// interrupt output, the vector and the poll byte combinationally from them.
// Assumes ack and poll_rd are never high together and NUM_LVL is a power of two.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [VEC_W-1:0]   wr_data,
    input  logic               ack,
    output logic [VEC_W-1:0]   vec_out,
    input  logic               poll_rd,
    output logic [VEC_W-1:0]   poll_data,
    output logic               int_out
);
    localparam int LW = $clog2(NUM_LVL);
    localparam logic [LW-1:0] TOP_LVL = LW'(NUM_LVL - 1);

    mode_t                  mode_q;
    logic [NUM_LVL-1:0]     mask_q;
    logic [VEC_W-LW-1:0]    base_q;
    logic [NUM_LVL-1:0]     isr_q;
    logic [LW-1:0]          low_q;

    logic [NUM_LVL-1:0]     pend;
    logic [NUM_LVL-1:0]     cand;
    logic [NUM_LVL-1:0]     take_1h;
    logic [NUM_LVL-1:0]     eoi_1h;
    logic [LW-1:0]          low_eff;
    logic                   req_hit, isr_hit, grant_ok, take, aeoi_on;
    logic [LW-1:0]          req_lvl, req_rank, isr_lvl, isr_rank;
    logic                   eoi_wr, eoi_spec, eoi_valid;
    logic [LW-1:0]          eoi_lvl;

    irq_capture #(.NUM_LVL(NUM_LVL)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (mode_q.level),
        .irq_in     (irq_in),
        .clr        (take_1h),
        .pend       (pend)
    );

    irq_resolver #(.NUM_LVL(NUM_LVL)) u_req_res (
        .req     (cand),
        .low_lvl (low_eff),
        .hit     (req_hit),
        .lvl     (req_lvl),
        .rank    (req_rank)
    );

    irq_resolver #(.NUM_LVL(NUM_LVL)) u_isr_res (
        .req     (isr_q),
        .low_lvl (low_eff),
        .hit     (isr_hit),
        .lvl     (isr_lvl),
        .rank    (isr_rank)
    );

    // Decide eligibility, nesting and the outputs seen by the host.
    always_comb begin
        aeoi_on   = mode_q.auto_eoi;
        low_eff   = mode_q.rotate ? low_q : TOP_LVL;
        cand      = pend & ~mask_q;
        grant_ok  = req_hit && (!isr_hit || (req_rank < isr_rank));
        int_out   = grant_ok;
        vec_out   = {base_q, (grant_ok ? req_lvl : TOP_LVL)};
        poll_data = {grant_ok, {(VEC_W-1-LW){1'b0}}, (grant_ok ? req_lvl : {LW{1'b0}})};
        take      = (ack | poll_rd) & grant_ok;
        take_1h   = take ? (NUM_LVL'(1) << req_lvl) : '0;
    end

    // Decode end-of-interrupt commands into a one-hot retire mask.
    always_comb begin
        eoi_wr    = wr_en && (wr_addr == REG_EOI);
        eoi_spec  = wr_data[LW];
        eoi_lvl   = eoi_spec ? wr_data[LW-1:0] : isr_lvl;
        eoi_valid = eoi_wr && (eoi_spec || isr_hit);
        eoi_1h    = eoi_valid ? (NUM_LVL'(1) << eoi_lvl) : '0;
    end

    // Configuration registers written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
            base_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_MODE: mode_q <= wr_data[2:0];
                REG_MASK: mask_q <= wr_data[NUM_LVL-1:0];
                REG_BASE: base_q <= wr_data[VEC_W-1:LW];
                default:  ;
            endcase
        end
    end

    // In-service register: set on acknowledge, cleared on retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q | (aeoi_on ? '0 : take_1h)) & ~eoi_1h;
        end
    end

    // Rotation pointer: the lowest-ranked level under rotating priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= TOP_LVL;
        end else if (mode_q.rotate) begin
            if (eoi_valid)
                low_q <= eoi_lvl;
            else if (take && aeoi_on)
                low_q <= req_lvl;
        end
    end
endmodule

// File: rtl/irq_prio_chk.sv
// Property checker for the priority interrupt controller, bound to the top.
// Assumes ack and poll_rd are exclusive; in-service checks skip cycles with
// an end-of-interrupt write.
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int VEC_W   = 8,
    localparam int LW     = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack,
    input logic               poll_rd,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [VEC_W-1:0]   wr_data,
    input logic               int_out,
    input logic [VEC_W-1:0]   vec_out,
    input logic [VEC_W-1:0]   poll_data,
    input logic [NUM_LVL-1:0] isr_q,
    input logic [NUM_LVL-1:0] mask_q,
    input logic [NUM_LVL-1:0] pend,
    input logic               aeoi_on
);
    logic eoi_cmd, base_cmd;
    assign eoi_cmd  = wr_en && (wr_addr == REG_EOI);
    assign base_cmd = wr_en && (wr_addr == REG_BASE);

    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(pend & ~mask_q)));

    // R6
    ack_marks_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi_on && !eoi_cmd)
        |=> ($countones(isr_q & ~$past(isr_q)) == 1));

    // R7
    spurious_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !poll_rd && !eoi_cmd) |=> $stable(isr_q));

    // R8
    ns_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && !wr_data[LW] && (isr_q != '0) && !ack && !poll_rd)
        |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

    // R11
    aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aeoi_on && !eoi_cmd) |=> ((isr_q & ~$past(isr_q)) == '0));

    // R12
    poll_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && int_out)
        |-> (poll_data[VEC_W-1] && (poll_data[LW-1:0] == vec_out[LW-1:0])));

    // R13
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !base_cmd |=> $stable(vec_out[VEC_W-1:LW]));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .poll_rd   (poll_rd),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .int_out   (int_out),
    .vec_out   (vec_out),
    .poll_data (poll_data),
    .isr_q     (isr_q),
    .mask_q    (mask_q),
    .pend      (pend),
    .aeoi_on   (aeoi_on)
);

// File: tb/irq_prio_ctrl_tb.sv
// Self-checking bench for irq_prio_ctrl: sweeps of request and mask
// patterns plus directed sequences for nesting, retire, rotation and polling.
module irq_prio_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       ack;
    logic [7:0] vec_out;
    logic       poll_rd;
    logic [7:0] poll_data;
    logic       int_out;
    int         n_vec = 0;
    int         n_bad = 0;
    logic [7:0] v;
    int         lowv;

    always #5 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack), .vec_out(vec_out),
        .poll_rd(poll_rd), .poll_data(poll_data), .int_out(int_out)
    );

    // Record one comparison; report mismatches.
    task automatic chk(input string req, input int act, input int exp_v);
        n_vec++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
        end
    endtask

    function automatic int low_set(input int x);
        for (int i = 0; i < 8; i++) if (x[i]) return i;
        return 7;
    endfunction

    task automatic tick();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; #1;
    endtask

    task automatic do_ack(output logic [7:0] got);
        ack = 1'b1; #1;
        got = vec_out;
        tick();
        ack = 1'b0; #1;
    endtask

    task automatic set_irq(input logic [7:0] x);
        irq = x; #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; irq = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ack = 1'b0; poll_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;

        // R1 reset state
        chk("R1 int_out", int_out, 0);
        chk("R1 vector", vec_out, 8'h07);
        poll_rd = 1'b1; #1;
        chk("R1 poll", poll_data, 0);
        tick(); poll_rd = 1'b0; #1;
        do_ack(v);
        chk("R1 spurious ack", v, 8'h07);

        // R5/R3 fixed priority sweep in level mode
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h48);
        for (int p = 1; p < 256; p++) begin
            set_irq(8'(p));
            chk("R3 level request", int_out, 1);
            chk("R5 vector", vec_out, 8'h48 | low_set(p));
            chk("R12 poll byte", poll_data, 8'h80 | low_set(p));
        end

        // R4 mask sweep with all lines high
        set_irq(8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr(2'd1, 8'(m));
            chk("R4 int_out", int_out, (m != 255) ? 1 : 0);
            chk("R4 vector", vec_out, 8'h48 | low_set(~m & 255));
        end
        wr(2'd1, 8'h00);

        // R13 low base bits ignored
        wr(2'd2, 8'h53);
        set_irq(8'h20);
        chk("R13 base", vec_out, 8'h55);

        // R6 nesting
        set_irq(8'h50);
        do_ack(v);
        chk("R6 ack vector", v, 8'h54);
        chk("R6 lower blocked", int_out, 0);
        set_irq(8'h54);
        chk("R6 nested higher", int_out, 1);
        do_ack(v);
        chk("R6 nested vector", v, 8'h52);
        // R9 specific retire of level 4 while 2 stays in service
        wr(2'd3, 8'h0C);
        set_irq(8'h08);
        chk("R9 level 2 still serving", int_out, 0);
        wr(2'd3, 8'h00);
        set_irq(8'h20);
        chk("R9 level 4 retired", int_out, 1);
        chk("R9 vector", vec_out, 8'h55);
        // R8 non-specific clears highest of {1,3}
        set_irq(8'h08);
        do_ack(v);
        chk("R8 setup 3", v, 8'h53);
        set_irq(8'h0A);
        do_ack(v);
        chk("R8 setup 1", v, 8'h51);
        set_irq(8'h04);
        chk("R8 before retire", int_out, 0);
        wr(2'd3, 8'h00);
        chk("R8 level 1 retired", int_out, 1);
        chk("R8 vector", vec_out, 8'h52);
        wr(2'd3, 8'h00);

        // R7 spurious acknowledge
        set_irq(8'h00);
        do_ack(v);
        chk("R7 spurious vector", v, 8'h57);
        set_irq(8'h80);
        chk("R7 level 7 not in service", int_out, 1);
        set_irq(8'h00);

        // R2 edge mode
        wr(2'd0, 8'h00);
        set_irq(8'h08);
        chk("R2 not before clock", int_out, 0);
        tick();
        chk("R2 captured", int_out, 1);
        chk("R2 vector", vec_out, 8'h53);
        set_irq(8'h00);
        chk("R2 withdrawn", int_out, 0);
        do_ack(v);
        chk("R2 withdrawn spurious", v, 8'h57);
        set_irq(8'h08);
        tick();
        do_ack(v);
        chk("R2 ack vector", v, 8'h53);
        wr(2'd3, 8'h00);
        chk("R2 held line no retrigger", int_out, 0);
        set_irq(8'h00); tick();
        set_irq(8'h08); tick();
        chk("R2 new edge", int_out, 1);
        do_ack(v);
        wr(2'd3, 8'h00);
        set_irq(8'h00); tick();

        // R10 rotating priority
        wr(2'd0, 8'h03);
        set_irq(8'hFF);
        chk("R10 start", vec_out, 8'h50);
        for (int k = 0; k < 8; k++) begin
            do_ack(v);
            chk("R10 ack", v, 8'h50 | k);
            if (k % 2 == 1) wr(2'd3, 8'(8 | k));
            else            wr(2'd3, 8'h00);
            chk("R10 rotated", vec_out, 8'h50 | ((k + 1) % 8));
        end
        set_irq(8'h08);
        do_ack(v);
        wr(2'd3, 8'h00);
        set_irq(8'hFF);
        chk("R10 after level 3 retired", vec_out, 8'h54);
        lowv = 3;
        wr(2'd0, 8'h01);
        chk("R10 fixed restored", vec_out, 8'h50);

        // R11 automatic end-of-interrupt
        wr(2'd0, 8'h05);
        set_irq(8'h04);
        do_ack(v);
        chk("R11 vector", v, 8'h52);
        chk("R11 no in-service", int_out, 1);
        set_irq(8'h06);
        do_ack(v);
        chk("R11 vector fixed", v, 8'h51);
        chk("R11 still requesting", int_out, 1);
        wr(2'd0, 8'h07);
        set_irq(8'hFF);
        for (int j = 0; j < 3; j++) begin
            do_ack(v);
            chk("R11 rotate ack", v, 8'h50 | ((lowv + 1) % 8));
            lowv = (lowv + 1) % 8;
        end
        chk("R11 rotated", vec_out, 8'h50 | ((lowv + 1) % 8));

        // R12 polling
        wr(2'd0, 8'h01);
        set_irq(8'h30);
        poll_rd = 1'b1; #1;
        chk("R12 poll hit", poll_data, 8'h84);
        tick(); poll_rd = 1'b0; #1;
        chk("R12 poll acknowledged", int_out, 0);
        poll_rd = 1'b1; #1;
        chk("R12 poll empty", poll_data, 8'h00);
        tick(); poll_rd = 1'b0; #1;
        wr(2'd3, 8'h00);
        chk("R12 retire after poll", int_out, 1);
        chk("R12 vector after poll", vec_out, 8'h54);
        set_irq(8'h00);

        finish_run();
    end
endmodule